// File: doc/BRIEF.md
# Display Controller Register Slave

This block is the two-wire serial slave that holds the adjustment and control settings of a display deflection and video controller. A bus master writes a block of settings by sending the device write address, one subaddress byte and then any number of data bytes. Each data byte after the first goes to the next location. The master reads the device by sending the read address. It then receives one status byte that reports horizontal lock and the X-ray protection latch. The read takes no subaddress.

Both bus lines are sampled by a faster system clock. Each line passes through two synchronizing flops and a persistence filter, so pulses shorter than the filter window never reach the protocol logic. The stored settings drive the controller's DACs and enables through a flat output vector. Two command bits act as pulses and are never stored: one clears the protection latch, the other reloads every default.

Top module: `disp_ctl_i2c_regs`

## Requirements
- R1: The slave acknowledges the address byte 0x8C (write) and 0x8D (read) only. After any other address byte it leaves SDA released and ignores the rest of the transfer until the next start.
- R2: In a write, the first byte after the address is taken as the subaddress and the second is stored at that location. Every byte, including the address, is acknowledged in the ninth clock.
- R3: Each further data byte in the same transfer goes to the next subaddress. A repeated start begins a new transfer that needs a new address and subaddress.
- R4: A read returns one byte, sent MSB first. Bit 7 is the horizontal lock input (0 = locked), bit 6 is the protection latch input, and bits 5:0 are zero. The inputs are sampled when the read address is acknowledged.
- R5: A stop condition ends the transfer and releases SDA. The slave changes SDA only while the filtered SCL is low.
- R6: A pulse on SCL or SDA that lasts fewer than FILT_CYCLES system clocks has no effect on the bus protocol.
- R7: After power-on reset, location 0 holds 0x40, with bit 7 (video enable) clear. Location 1 holds 0xC0, with bit 7 (horizontal drive enable) set. All other locations hold 0x40.
- R8: A write to a subaddress of 20 or above is acknowledged and changes no location.
- R9: Writing a byte with bit 7 set to location 9 gives a protection-clear pulse one clock long. Bit 7 of location 9 always reads 0 on the outputs. Bits 6:0 are stored.
- R10: Writing a byte with bit 7 set to location 11 reloads every location with its default value, location 11 included. Without bit 7, bits 6:0 are stored and bit 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Power-on reset, active low |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| hlock_n | input | 1 | Horizontal lock status, low when locked |
| prot_latched | input | 1 | X-ray protection latch state |
| sda_pull | output | 1 | Drive SDA low when 1 |
| prot_clr | output | 1 | One-clock pulse that clears the protection latch |
| regs_flat | output | 160 | Settings, location i at bits [8i+7:8i] |

## Verification
Single-byte writes and three-byte bursts are both used. Comparing their results separates the subaddress byte from data bytes and shows whether the increment happens. A repeated start in the middle of a transfer, a foreign address and a burst that runs past location 19 check where writes must stop. Reads taken with two different status input patterns show the bit positions and MSB-first order. A burst carrying sub-window spikes on both lines checks the filter: a spike that got through would add a clock or fake a start and corrupt the stored byte. Writes of the two command bits show pulse and reload behaviour apart from ordinary stores.

// File: rtl/disp_ctl_i2c_regs.sv
module disp_ctl_i2c_regs #(
  parameter int         NUM_REGS    = 20,
  parameter int         FILT_CYCLES = 3,
  parameter logic [6:0] DEV_ADDR    = 7'h46,
  parameter int         HDRV_SUB    = 1,
  parameter int         PROT_SUB    = 9,
  parameter int         RESET_SUB   = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  input  logic                  hlock_n,
  input  logic                  prot_latched,
  output logic                  sda_pull,
  output logic                  prot_clr,
  output logic [NUM_REGS*8-1:0] regs_flat
);
  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam int IW = $clog2(NUM_REGS);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SUB, S_DATA, S_ACK, S_RD} st_t;

  function automatic logic [7:0] dflt(int i);
    return (i == HDRV_SUB) ? 8'hC0 : 8'h40;
  endfunction

  // line 0 = SCL, line 1 = SDA
  logic [1:0] s1, s2, flt, flt_d;
  logic [CW-1:0] cnt [2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 2'b11; s2 <= 2'b11; flt_d <= 2'b11;
    end else begin
      s1 <= {sda_in, scl_in}; s2 <= s1; flt_d <= flt;
    end

  for (genvar g = 0; g < 2; g++) begin : g_filt
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        flt[g] <= 1'b1; cnt[g] <= '0;
      end else if (s2[g] == flt[g]) begin
        cnt[g] <= '0;
      end else if (cnt[g] == CW'(FILT_CYCLES - 1)) begin
        flt[g] <= s2[g]; cnt[g] <= '0;
      end else begin
        cnt[g] <= cnt[g] + 1'b1;
      end
  end

  logic scl_rise, scl_fall, bus_start, bus_stop;
  assign scl_rise  =  flt[0] & ~flt_d[0];
  assign scl_fall  = ~flt[0] &  flt_d[0];
  assign bus_start =  flt[0] &  flt_d[0] & ~flt[1] &  flt_d[1];
  assign bus_stop  =  flt[0] &  flt_d[0] &  flt[1] & ~flt_d[1];

  st_t        state, nxt;
  logic [3:0] bitcnt;
  logic [7:0] shreg, sub, tx;
  logic [7:0] regs [NUM_REGS];
  logic       in_range, is_cmd;

  assign in_range = sub < 8'(NUM_REGS);
  assign is_cmd   = (sub == 8'(PROT_SUB)) || (sub == 8'(RESET_SUB));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; nxt <= S_IDLE; bitcnt <= '0;
      shreg <= '0; sub <= '0; tx <= '0;
      sda_pull <= 1'b0; prot_clr <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= dflt(i);
    end else begin
      prot_clr <= 1'b0;
      if (bus_start) begin
        state <= S_ADDR; bitcnt <= '0; sda_pull <= 1'b0;
      end else if (bus_stop) begin
        state <= S_IDLE; sda_pull <= 1'b0;
      end else if (scl_rise) begin
        if (state == S_ADDR || state == S_SUB || state == S_DATA) begin
          shreg  <= {shreg[6:0], flt[1]};
          bitcnt <= bitcnt + 1'b1;
        end else if (state == S_RD) begin
          bitcnt <= bitcnt + 1'b1;
        end
      end else if (scl_fall) begin
        case (state)
          S_ADDR: if (bitcnt == 4'd8) begin
            if (shreg == {DEV_ADDR, 1'b0}) begin
              sda_pull <= 1'b1; nxt <= S_SUB; state <= S_ACK;
            end else if (shreg == {DEV_ADDR, 1'b1}) begin
              sda_pull <= 1'b1; nxt <= S_RD; state <= S_ACK;
              tx <= {hlock_n, prot_latched, 6'b0};
            end else begin
              state <= S_IDLE;
            end
          end
          S_SUB: if (bitcnt == 4'd8) begin
            sub <= shreg; sda_pull <= 1'b1; nxt <= S_DATA; state <= S_ACK;
          end
          S_DATA: if (bitcnt == 4'd8) begin
            sda_pull <= 1'b1; nxt <= S_DATA; state <= S_ACK;
            sub <= sub + 1'b1;
            if (sub == 8'(RESET_SUB) && shreg[7]) begin
              for (int i = 0; i < NUM_REGS; i++) regs[i] <= dflt(i);
            end else if (in_range) begin
              regs[sub[IW-1:0]] <= is_cmd ? {1'b0, shreg[6:0]} : shreg;
            end
            if (sub == 8'(PROT_SUB) && shreg[7]) prot_clr <= 1'b1;
          end
          S_ACK: begin
            bitcnt <= '0; state <= nxt;
            if (nxt == S_RD) begin
              sda_pull <= ~tx[7]; tx <= {tx[6:0], 1'b0};
            end else begin
              sda_pull <= 1'b0;
            end
          end
          S_RD: if (bitcnt == 4'd8) begin
            sda_pull <= 1'b0; state <= S_IDLE;
          end else begin
            sda_pull <= ~tx[7]; tx <= {tx[6:0], 1'b0};
          end
          default: ;
        endcase
      end
    end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign regs_flat[g*8 +: 8] = regs[g];
  end

  a_r5_drive_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !flt[0]);
  a_r5_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !sda_pull);
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_pull);
  a_r9_clr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    prot_clr |=> !prot_clr);
  a_r2_store_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_flat) |-> $past(scl_fall));
endmodule

// File: tb/disp_ctl_i2c_regs_tb.sv
module disp_ctl_i2c_regs_tb;
  localparam int N = 20;
  localparam int Q = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic hlock_n = 1'b1, prot_latched = 1'b0;
  logic sda_pull, prot_clr;
  logic [N*8-1:0] regs_flat;
  wire  sda_line = sda_m & ~sda_pull;

  always #10 clk = ~clk;

  disp_ctl_i2c_regs u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .hlock_n(hlock_n), .prot_latched(prot_latched),
    .sda_pull(sda_pull), .prot_clr(prot_clr), .regs_flat(regs_flat));

  typedef struct { string req; logic [31:0] exp; } item_t;
  item_t sbq[$];
  logic [31:0] obs_val;
  event obs_ev;
  int n_vec = 0, n_fail = 0, clr_seen = 0, clr_exp = 0;
  logic [7:0] mdl [N];

  always @(posedge clk) if (prot_clr) clr_seen++;

  always @(obs_ev) begin
    item_t it;
    it = sbq.pop_front();
    n_vec++;
    if (obs_val !== it.exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", it.req, obs_val, it.exp);
    end
  end

  task automatic chk(string r, logic [31:0] exp, logic [31:0] act);
    item_t it;
    it.req = r; it.exp = exp;
    sbq.push_back(it);
    obs_val = act;
    -> obs_ev;
    #1;
  endtask

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] dflt(int i);
    return (i == 1) ? 8'hC0 : 8'h40;
  endfunction

  task automatic model_write(logic [7:0] sub, logic [7:0] d);
    if (sub == 8'd11 && d[7]) begin
      for (int i = 0; i < N; i++) mdl[i] = dflt(i);
    end else if (sub < 8'(N)) begin
      mdl[sub] = (sub == 8'd9 || sub == 8'd11) ? {1'b0, d[6:0]} : d;
    end
    if (sub == 8'd9 && d[7]) clr_exp++;
  endtask

  task automatic check_regs(string r);
    for (int i = 0; i < N; i++) chk(r, {24'b0, mdl[i]}, {24'b0, regs_flat[i*8 +: 8]});
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1;
      if (glitch && i == 3 && b[i]) begin
        wq(Q/2); sda_m = 1'b0; wq(2); sda_m = 1'b1; wq(2*Q - Q/2 - 2);
      end else wq(2*Q);
      scl_m = 1'b0;
      if (glitch && i == 3) begin
        wq(Q/2); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(Q - Q/2 - 2);
      end else wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    ack = !sda_line;
    wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
      b[i] = sda_line;
      wq(Q); scl_m = 1'b0; wq(Q);
    end
    sda_m = !mack; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic write_regs(string r, logic [7:0] sub, logic [7:0] d [4], int n, bit glitch);
    bit ack;
    bus_start();
    send_byte(8'h8C, 1'b0, ack); chk({r, " addr ack"}, 1, {31'b0, ack});
    send_byte(sub, 1'b0, ack);   chk({r, " sub ack"}, 1, {31'b0, ack});
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], glitch, ack); chk({r, " data ack"}, 1, {31'b0, ack});
      model_write(sub + 8'(k), d[k]);
    end
    bus_stop();
  endtask

  task automatic read_status(string r, logic [7:0] exp);
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'h8D, 1'b0, ack); chk({r, " read addr ack"}, 1, {31'b0, ack});
    recv_byte(b, 1'b0);
    bus_stop();
    chk({r, " status byte"}, {24'b0, exp}, {24'b0, b});
    chk("R5 released after stop", 0, {31'b0, sda_pull});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d [4];
    bit ack;
    for (int i = 0; i < N; i++) mdl[i] = dflt(i);
    wq(5); rst_n = 1'b1; wq(5);

    // R7 reset defaults
    check_regs("R7 reset default");
    chk("R7 sda released", 0, {31'b0, sda_pull});
    chk("R7 no clear pulse", 0, {31'b0, prot_clr});

    // R2 single write
    d = '{8'h5A, 8'h00, 8'h00, 8'h00};
    write_regs("R2", 8'd3, d, 1, 1'b0);
    check_regs("R2 single store");

    // R3 burst
    d = '{8'hA1, 8'hA2, 8'hA3, 8'h00};
    write_regs("R3", 8'd4, d, 3, 1'b0);
    check_regs("R3 burst increment");

    // R1 foreign address
    bus_start();
    send_byte(8'h90, 1'b0, ack); chk("R1 foreign addr nack", 0, {31'b0, ack});
    send_byte(8'h05, 1'b0, ack); chk("R1 ignored byte nack", 0, {31'b0, ack});
    send_byte(8'h77, 1'b0, ack); chk("R1 ignored byte nack", 0, {31'b0, ack});
    bus_stop();
    check_regs("R1 nothing written");

    // R3 repeated start ends the burst
    bus_start();
    send_byte(8'h8C, 1'b0, ack); chk("R3 addr ack", 1, {31'b0, ack});
    send_byte(8'h02, 1'b0, ack); chk("R3 sub ack", 1, {31'b0, ack});
    send_byte(8'h12, 1'b0, ack); chk("R3 data ack", 1, {31'b0, ack});
    model_write(8'h02, 8'h12);
    bus_start();
    send_byte(8'h8C, 1'b0, ack); chk("R3 restart addr ack", 1, {31'b0, ack});
    send_byte(8'h00, 1'b0, ack); chk("R3 restart sub ack", 1, {31'b0, ack});
    send_byte(8'h81, 1'b0, ack); chk("R3 restart data ack", 1, {31'b0, ack});
    model_write(8'h00, 8'h81);
    bus_stop();
    check_regs("R3 repeated start");

    // R4 status reads
    hlock_n = 1'b1; prot_latched = 1'b0; wq(2);
    read_status("R4 unlocked", 8'h80);
    hlock_n = 1'b0; prot_latched = 1'b1; wq(2);
    read_status("R4 latched", 8'h40);

    // R8 past the last location
    d = '{8'h11, 8'h22, 8'h33, 8'h00};
    write_regs("R8", 8'd19, d, 3, 1'b0);
    check_regs("R8 out of range ignored");

    // R6 spikes on both lines
    d = '{8'h3C, 8'hC3, 8'h3C, 8'h00};
    write_regs("R6", 8'd7, d, 3, 1'b1);
    check_regs("R6 spikes rejected");

    // R9 protection clear
    d = '{8'h85, 8'h00, 8'h00, 8'h00};
    write_regs("R9", 8'd9, d, 1, 1'b0);
    chk("R9 clear pulse count", clr_exp, clr_seen);
    check_regs("R9 command bit not stored");

    // R10 store then reload
    d = '{8'h2B, 8'h00, 8'h00, 8'h00};
    write_regs("R10", 8'd11, d, 1, 1'b0);
    check_regs("R10 plain store");
    d = '{8'h80, 8'h00, 8'h00, 8'h00};
    write_regs("R10", 8'd11, d, 1, 1'b0);
    check_regs("R10 defaults reloaded");
    chk("R9 no extra clear", clr_exp, clr_seen);

    wq(5);
    if (sbq.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d left expected 0", sbq.size());
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule